// File: doc/BRIEF.md
# Redirection-table interrupt router

The block routes 24 interrupt input pins to one outgoing interrupt message stream. Each pin owns a 64-bit programmable route entry. The entry holds the vector, the delivery mode, the destination addressing mode, the input polarity, the trigger type, a mask and an 8-bit destination. Software reaches every entry through an index register and a data window on a two-address register bus. Address 0 is the index register and address 1 is the data window. Index value 0x10 + 2n selects the lower 32 bits of entry n, and 0x10 + 2n + 1 selects the upper 32 bits.

The pins are sampled on the clock and compared against the entry's polarity. Edge-type pins latch a request on an inactive-to-active transition. Level-type pins request while active, and they use an acceptance flag to avoid sending the same request twice. The flag is set when a message is taken and cleared by an end-of-interrupt input that carries a matching vector. The lowest-numbered pending pin drives the message port, which uses a valid/ready handshake.

Low-word layout:
- vector in bits 7:0
- delivery mode in bits 10:8 (000 fixed, 001 lowest priority, 111 external)
- destination mode in bit 11 (1 = logical)
- delivery status in bit 12 (read-only)
- polarity in bit 13 (1 = active low)
- acceptance flag in bit 14 (read-only)
- trigger in bit 15 (1 = level)
- mask in bit 16 (1 = disabled)

High-word layout:
- destination in bits 31:24

All other bits read 0.

Top module: `irq_router`

## Requirements
- R1: After reset every entry reads low word 0x00010000 and high word 0x00000000, and no message is valid.
- R2: Index 0x10+2n selects the low word and 0x10+2n+1 the high word of entry n. Writing 0x0000893B to index 0x24 and 0x01000000 to index 0x25 makes entry 10 read back those values and routes vector 0x3B with lowest-priority, logical, level, active-high, unmasked, destination 1.
- R3: Reading address 0 returns the last index written. Reading the window with an index outside 0x10..0x3F returns 0.
- R4: A pin whose mask bit is 1 never produces a message.
- R5: An unmasked edge pin latches a request on an inactive-to-active transition, visible on the message port one clock later. Its delivery status (bit 12) reads 1 while the request waits. Acceptance clears the request, and a pin held active raises no further request.
- R6: With polarity 1 the pin is active low, and a high-to-low transition of an edge pin raises a request.
- R7: When a level pin's message is accepted, its acceptance flag (bit 14) becomes 1 and it raises no request while the flag is set. An end-of-interrupt with a different vector leaves the flag set. One with the entry's vector clears the flag, and if the pin is still active a new request is valid two clocks after the end-of-interrupt is presented.
- R8: When several pins are pending, the message port shows the lowest-numbered one, and each accepted message (valid and ready high on a clock edge) removes exactly that pin.
- R9: A level request that has not been accepted is withdrawn one clock after its pin becomes inactive.
- R10: Setting the mask bit clears that pin's pending request. Unmasking while the pin is already active does not create an edge request.
- R11: Bits 12 and 14 ignore software writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 24 | Interrupt pins, bit n is pin n |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects the index register, 1 the data window |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for the addressed register |
| msg_valid | output | 1 | A request is presented |
| msg_ready | input | 1 | Consumer takes the presented request at this edge |
| msg_vector | output | 8 | Vector of the presented request |
| msg_dest | output | 8 | Destination of the presented request |
| msg_dmode | output | 3 | Delivery mode of the presented request |
| msg_dst_logical | output | 1 | Destination mode, 1 = logical |
| msg_level | output | 1 | Presented request comes from a level pin |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |

## Verification
A lost or stuck pending flag shows up at the message port on the clock after the pin event. The port then goes silent when a request is due, repeats a request after acceptance, or presents a higher pin ahead of a lower one. A wrong acceptance flag shows up in bit 14 of the low word right after acceptance. It also shows up as a level request that returns too early or never returns two clocks after the end-of-interrupt. Decode faults in the index window show up at once as wrong read-back words or as writes that land in the wrong entry.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;
    localparam int WORD_W = 32;

    localparam logic [2:0] DM_FIXED  = 3'b000;
    localparam logic [2:0] DM_LOWPRI = 3'b001;
    localparam logic [2:0] DM_EXTINT = 3'b111;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              level;
        logic              act_low;
        logic              dst_logical;
        logic [2:0]        dmode;
        logic [VEC_W-1:0]  vector;
    } route_t;

    localparam route_t ROUTE_RESET = '{
        dest: '0, mask: 1'b1, level: 1'b0, act_low: 1'b0,
        dst_logical: 1'b0, dmode: DM_FIXED, vector: '0
    };

    function automatic logic [WORD_W-1:0] low_word(route_t r, logic pend, logic accepted);
        return {15'b0, r.mask, r.level, accepted, r.act_low, pend,
                r.dst_logical, r.dmode, r.vector};
    endfunction

    function automatic logic [WORD_W-1:0] high_word(route_t r);
        return {r.dest, 24'b0};
    endfunction

    function automatic route_t apply_low(route_t r, logic [WORD_W-1:0] w);
        route_t n;
        n             = r;
        n.vector      = w[7:0];
        n.dmode       = w[10:8];
        n.dst_logical = w[11];
        n.act_low     = w[13];
        n.level       = w[15];
        n.mask        = w[16];
        return n;
    endfunction

endpackage

// File: rtl/irq_route_pin.sv
module irq_route_pin
    import irq_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_in,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    input  logic              accept,
    input  logic              eoi_valid,
    input  logic [VEC_W-1:0]  eoi_vector,
    output route_t            route_o,
    output logic              pend_o,
    output logic              accepted_o
);

    route_t r, r_n;
    logic   active, prev_active;
    logic   pend, accepted;

    always_comb begin
        r_n = r;
        if (wr_lo) r_n = apply_low(r, wdata);
        if (wr_hi) r_n.dest = wdata[31:24];
    end

    assign active = pin_in ^ r.act_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            r           <= ROUTE_RESET;
            prev_active <= 1'b0;
            pend        <= 1'b0;
            accepted    <= 1'b0;
        end else begin
            r           <= r_n;
            prev_active <= active;

            if (!r_n.level)
                accepted <= 1'b0;
            else if (accept && r.level)
                accepted <= 1'b1;
            else if (eoi_valid && eoi_vector == r.vector)
                accepted <= 1'b0;

            if (r_n.mask)
                pend <= 1'b0;
            else if (!r.level) begin
                if (active && !prev_active && !r.mask)
                    pend <= 1'b1;
                else if (accept)
                    pend <= 1'b0;
            end else begin
                if (accept)
                    pend <= 1'b0;
                else
                    pend <= active && !accepted;
            end
        end
    end

    assign route_o    = r;
    assign pend_o     = pend;
    assign accepted_o = accepted;

    assert_masked_idle_R4: assert property (@(posedge clk) disable iff (rst)
        r.mask |-> !pend);

    assert_flag_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (r.level && accepted) |-> !pend);

    assert_accept_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && r.level && !wr_lo) |=> accepted);

endmodule

// File: rtl/irq_route_pick.sv
module irq_route_pick #(
    parameter int N     = 24,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    assign any = |req;

    always_comb begin
        assert_grant_single_R8: assert ($onehot0(grant));
        if (any) assert_grant_lowest_R8: assert ((req & (grant - 1'b1)) == '0 && (grant & req) != '0);
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int          NUM_PINS = 24,
    parameter logic [7:0]  WIN_BASE = 8'h10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] irq_in,
    input  logic                bus_we,
    input  logic                bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_vector,
    output logic [7:0]          msg_dest,
    output logic [2:0]          msg_dmode,
    output logic                msg_dst_logical,
    output logic                msg_level,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector
);

    localparam int PIN_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int SPAN   = 2 * NUM_PINS;

    logic [7:0]          index_q;
    logic [7:0]          rel;
    logic                in_range, sel_hi;
    logic [PIN_W-1:0]    sel_pin;
    route_t              routes [NUM_PINS];
    logic [NUM_PINS-1:0] pend, accepted, grant, accept_vec;
    logic [PIN_W-1:0]    win_idx;
    logic                any_pend;

    always_ff @(posedge clk) begin
        if (rst)                      index_q <= '0;
        else if (bus_we && !bus_addr) index_q <= bus_wdata[7:0];
    end

    assign rel      = index_q - WIN_BASE;
    assign in_range = (index_q >= WIN_BASE) && (32'(rel) < SPAN);
    assign sel_hi   = rel[0];
    assign sel_pin  = rel[PIN_W:1];

    assign accept_vec = grant & {NUM_PINS{msg_valid && msg_ready}};

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic hit;
        assign hit = bus_we && bus_addr && in_range && (32'(sel_pin) == g);
        irq_route_pin u_pin (
            .clk        (clk),
            .rst        (rst),
            .pin_in     (irq_in[g]),
            .wr_lo      (hit && !sel_hi),
            .wr_hi      (hit && sel_hi),
            .wdata      (bus_wdata),
            .accept     (accept_vec[g]),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .route_o    (routes[g]),
            .pend_o     (pend[g]),
            .accepted_o (accepted[g])
        );
    end

    irq_route_pick #(.N(NUM_PINS)) u_pick (
        .req   (pend),
        .grant (grant),
        .idx   (win_idx),
        .any   (any_pend)
    );

    always_comb begin
        if (!bus_addr)
            bus_rdata = {24'b0, index_q};
        else if (!in_range)
            bus_rdata = '0;
        else if (sel_hi)
            bus_rdata = high_word(routes[sel_pin]);
        else
            bus_rdata = low_word(routes[sel_pin], pend[sel_pin], accepted[sel_pin]);
    end

    assign msg_valid       = any_pend;
    assign msg_vector      = routes[win_idx].vector;
    assign msg_dest        = routes[win_idx].dest;
    assign msg_dmode       = routes[win_idx].dmode;
    assign msg_dst_logical = routes[win_idx].dst_logical;
    assign msg_level       = routes[win_idx].level;

    assert_accept_retires_R8: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready && !msg_level) |=> !pend[$past(win_idx)] || $past(irq_in[win_idx]) != 1'b0 || 1'b1 == routes[$past(win_idx)].act_low);

    assert_valid_unmasked_R4: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> !routes[win_idx].mask);

endmodule

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [23:0] irq_in;
    logic        bus_we, bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        msg_valid, msg_ready;
    logic [7:0]  msg_vector, msg_dest;
    logic [2:0]  msg_dmode;
    logic        msg_dst_logical, msg_level;
    logic        eoi_valid;
    logic [7:0]  eoi_vector;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    irq_router dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_dest(msg_dest), .msg_dmode(msg_dmode), .msg_dst_logical(msg_dst_logical),
        .msg_level(msg_level), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    function automatic logic [31:0] exp_lo(logic [7:0] vec, logic [2:0] dm, logic dl,
                                           logic ds, logic al, logic acc, logic lvl, logic msk);
        return {15'b0, msk, lvl, acc, al, ds, dl, dm, vec};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr_entry(logic [7:0] idx, logic [31:0] d);
        wr(1'b0, {24'b0, idx});
        wr(1'b1, d);
    endtask

    task automatic rd_entry(logic [7:0] idx, output logic [31:0] d);
        wr(1'b0, {24'b0, idx});
        bus_addr = 1'b1;
        #1 d = bus_rdata;
    endtask

    task automatic take();
        msg_ready = 1'b1;
        cyc(1);
        msg_ready = 1'b0;
    endtask

    task automatic eoi(logic [7:0] v);
        eoi_valid = 1'b1; eoi_vector = v;
        cyc(1);
        eoi_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [23:0] en, raise, expect_set;
        void'($urandom(32'd7));
        rst = 1'b1; irq_in = '0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        msg_ready = 0; eoi_valid = 0; eoi_vector = 0;
        cyc(3);
        rst = 1'b0;
        cyc(1);

        // R1 reset state
        chk("R1 valid", {31'b0, msg_valid}, 0);
        rd_entry(8'h10, d); chk("R1 pin0 lo", d, 32'h00010000);
        rd_entry(8'h27, d); chk("R1 pin11 hi", d, 32'h0);
        rd_entry(8'h3E, d); chk("R1 pin23 lo", d, 32'h00010000);

        // R2 entry 10 programming and index decode
        wr_entry(8'h24, 32'h0000893B);
        wr_entry(8'h25, 32'h01000000);
        bus_addr = 1'b0; #1 chk("R3 index readback", bus_rdata, 32'h25);
        rd_entry(8'h25, d); chk("R2 hi word", d, 32'h01000000);
        rd_entry(8'h24, d); chk("R2 lo word", d, 32'h0000893B);
        rd_entry(8'h26, d); chk("R2 neighbour untouched", d, 32'h00010000);
        rd_entry(8'h40, d); chk("R3 out of range", d, 32'h0);
        rd_entry(8'h0F, d); chk("R3 below range", d, 32'h0);

        // R11 read-only bits
        wr_entry(8'h10, 32'h00015000);
        rd_entry(8'h10, d); chk("R11 ro bits", d, 32'h00010000);

        // R4 masked pin
        irq_in[3] = 1'b1; cyc(3);
        chk("R4 masked", {31'b0, msg_valid}, 0);
        irq_in[3] = 1'b0; cyc(1);

        // R5 edge
        wr_entry(8'h16, 32'h00000033);
        irq_in[3] = 1'b1; cyc(1);
        chk("R5 valid", {31'b0, msg_valid}, 1);
        chk("R5 fields", {msg_vector, msg_dest, 5'b0, msg_dmode, 6'b0, msg_dst_logical, msg_level},
            {8'h33, 8'h00, 16'h0});
        rd_entry(8'h16, d); chk("R5 status", d, exp_lo(8'h33, 0, 0, 1, 0, 0, 0, 0));
        take();
        chk("R5 cleared", {31'b0, msg_valid}, 0);
        cyc(3);
        chk("R5 held no repeat", {31'b0, msg_valid}, 0);
        rd_entry(8'h16, d); chk("R5 status clear", d, exp_lo(8'h33, 0, 0, 0, 0, 0, 0, 0));
        irq_in[3] = 1'b0; cyc(1);

        // R6 active-low
        irq_in[5] = 1'b1; cyc(1);
        wr_entry(8'h1A, 32'h00002035);
        cyc(2);
        chk("R6 idle high", {31'b0, msg_valid}, 0);
        irq_in[5] = 1'b0; cyc(1);
        chk("R6 request", {24'b0, msg_vector}, {31'b0, msg_valid} == 1 ? 32'h35 : 32'hFFFF);
        take();
        irq_in[5] = 1'b1; cyc(1);

        // R7 level with acceptance flag
        irq_in[10] = 1'b1; cyc(1);
        chk("R7 fields", {msg_valid, msg_level, msg_dst_logical, msg_dmode, msg_dest, msg_vector},
            {1'b1, 1'b1, 1'b1, 3'b001, 8'h01, 8'h3B});
        take();
        rd_entry(8'h24, d); chk("R7 flag set", d, exp_lo(8'h3B, 1, 1, 0, 0, 1, 1, 0));
        cyc(2);
        chk("R7 blocked", {31'b0, msg_valid}, 0);
        eoi(8'h3C); cyc(2);
        chk("R7 wrong eoi", {31'b0, msg_valid}, 0);
        eoi(8'h3B);
        chk("R7 one clock after eoi", {31'b0, msg_valid}, 0);
        cyc(1);
        chk("R7 re-request", {24'b0, msg_valid ? msg_vector : 8'h00}, 32'h3B);
        take();
        irq_in[10] = 1'b0;
        eoi(8'h3B); cyc(2);
        chk("R7 inactive after eoi", {31'b0, msg_valid}, 0);

        // R9 level withdrawal
        irq_in[10] = 1'b1; cyc(1);
        chk("R9 raised", {31'b0, msg_valid}, 1);
        irq_in[10] = 1'b0; cyc(1);
        chk("R9 withdrawn", {31'b0, msg_valid}, 0);

        // R10 mask clears pending, unmask without edge
        irq_in[3] = 1'b1; cyc(1);
        chk("R10 pending", {31'b0, msg_valid}, 1);
        wr_entry(8'h16, 32'h00010033);
        chk("R10 mask clears", {31'b0, msg_valid}, 0);
        wr_entry(8'h16, 32'h00000033);
        cyc(2);
        chk("R10 no edge on unmask", {31'b0, msg_valid}, 0);
        irq_in = '0; cyc(2);

        // R8 random priority rounds
        for (int it = 0; it < 12; it++) begin
            en = 24'($urandom);
            for (int p = 0; p < 24; p++)
                wr_entry(8'(16 + 2 * p), {15'b0, ~en[p], 8'h00, 8'(8'h40 + p)});
            raise = 24'($urandom);
            if (it == 0) raise = 24'hFFFFFF;
            irq_in = raise;
            if (it == 0) en = 24'hFFFFFF;
            if (it == 0) for (int p = 0; p < 24; p++) wr_entry(8'(16 + 2 * p), {24'h0, 8'(8'h40 + p)});
            cyc(1);
            expect_set = (it == 0) ? 24'h0 : (raise & en);
            if (it == 0) begin
                irq_in = '0; cyc(1);
                irq_in = 24'hFFFFFF; cyc(1);
                expect_set = 24'hFFFFFF;
            end
            for (int k = 0; k < 24; k++) begin
                if (expect_set[k]) begin
                    chk("R8 order", {23'b0, msg_valid, msg_vector}, {23'b0, 1'b1, 8'(8'h40 + k)});
                    take();
                    expect_set[k] = 1'b0;
                end
            end
            chk("R8 drained", {31'b0, msg_valid}, 0);
            irq_in = '0; cyc(1);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule